// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Read Pipelining

Two ports share one storage array. Each port can read or write any word in any cycle, including the word the other port is using. Every port registers its address, write data and control on the rising clock edge. The array commits writes at the following edge, and the same registered request also drives the read path.

Each port has its own static mode input. In flow-through mode, read data comes straight from the array after the edge that captured the request. In pipelined mode, read data passes through one more output register.

The output drive flags stand in for tri-state pads, one flag per byte lane. Selection and lane gating travel through the same pipeline as the data. The output enable gates the flags combinationally, after every register.

A lane whose flag is low shows zero on its data bits. Both ports run from one clock. The storage depth and word width are parameters; the word always has two byte lanes.

Top module: `dpram_dual`

## Requirements
- R1: A port is selected only when its `x_cs_n` is 0 and its `x_cs` is 1. A deselected port writes nothing, and after its next edge it drives no lane.
- R2: `x_ub_n` (active low) enables the upper lane, data bits 15:8, reported on `x_drive[1]`. `x_lb_n` (active low) enables the lower lane, bits 7:0, reported on `x_drive[0]`. With both high, the port neither reads nor writes.
- R3: With `x_rnw` = 0, a selected port writes only its enabled lanes at the address captured on the edge, and other lanes keep their contents. A write cycle drives no lane.
- R4: With `x_pipe` = 0 and `x_rnw` = 1, the enabled lanes show the stored word and their drive flags go high after the same edge that captured the address.
- R5: With `x_pipe` = 1, the same read result appears one edge later than in R4.
- R6: Deselection or lane disable turns the drive flags off after the next edge in flow-through mode, and one edge later in pipelined mode. In pipelined mode, a newly selected port drives only after its second edge.
- R7: `x_oe_n` = 1 forces every drive flag of that port to 0 with no clock edge. Returning it to 0 restores the flags at once.
- R8: Every lane whose drive flag is 0 shows zero on its data bits.
- R9: While a port keeps reading the same address and nothing writes that word, its read output stays constant across edges.
- R10: When both ports write the same word in the same cycle, the left port's data is stored in every lane both ports write. A lane written by only one port takes that port's data.
- R11: A read that shares a cycle with the other port's write to the same word returns the old contents. The next access returns the new data.
- R12: While the synchronous reset `rst` is high, both ports drive no lane after the first reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_cs_n | input | 1 | Left port select, active low |
| l_cs | input | 1 | Left port select, active high |
| l_rnw | input | 1 | Left port: 1 read, 0 write |
| l_ub_n | input | 1 | Left port upper lane enable, active low |
| l_lb_n | input | 1 | Left port lower lane enable, active low |
| l_oe_n | input | 1 | Left port output enable, active low, combinational |
| l_pipe | input | 1 | Left port read mode: 0 flow-through, 1 pipelined |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data |
| l_drive | output | 2 | Left port per-lane drive flags |
| r_cs_n | input | 1 | Right port select, active low |
| r_cs | input | 1 | Right port select, active high |
| r_rnw | input | 1 | Right port: 1 read, 0 write |
| r_ub_n | input | 1 | Right port upper lane enable, active low |
| r_lb_n | input | 1 | Right port lower lane enable, active low |
| r_oe_n | input | 1 | Right port output enable, active low, combinational |
| r_pipe | input | 1 | Right port read mode: 0 flow-through, 1 pipelined |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data |
| r_drive | output | 2 | Right port per-lane drive flags |

## Verification
A request driven before edge k gives its flow-through result after edge k, so the bench samples it at the falling edge that follows. A write becomes visible to any request captured at edge k+1 or later. A pipelined result appears only after edge k+1, so the bench samples at the falling edge one cycle later than for flow-through, and it also samples at the earlier falling edge to show the result is not there yet. The output-enable checks sample within the same low clock phase, a fraction of a nanosecond after the change and with no edge in between, because that path holds no register.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int PORTS   = 2;
    localparam int LANES   = 2;
    localparam int P_LEFT  = 0;
    localparam int P_RIGHT = 1;

    typedef enum logic {
        RD_FLOW = 1'b0,
        RD_PIPE = 1'b1
    } rd_mode_e;

    function automatic logic port_selected(input logic cs_n, input logic cs);
        return !cs_n && cs;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic ub_n,
                                                   input logic lb_n,
                                                   input logic sel);
        return {~ub_n & sel, ~lb_n & sel};
    endfunction

endpackage

// File: rtl/dpram_port_in.sv
module dpram_port_in
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              rnw,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_wdata,
    output logic [LANES-1:0]  q_wr,
    output logic [LANES-1:0]  q_rd
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  wr;
        logic [LANES-1:0]  rd;
    } req_t;

    req_t             req_d;
    req_t             req_q;
    logic [LANES-1:0] lanes;

    always_comb begin
        lanes       = lane_mask(ub_n, lb_n, port_selected(cs_n, cs));
        req_d.addr  = addr;
        req_d.wdata = wdata;
        req_d.wr    = rnw ? '0 : lanes;
        req_d.rd    = rnw ? lanes : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign q_addr  = req_q.addr;
    assign q_wdata = req_q.wdata;
    assign q_wr    = req_q.wr;
    assign q_rd    = req_q.rd;

    // R1: an unselected port captures no access of any kind
    p_deselect_no_access_r1: assert property (@(posedge clk) disable iff (rst)
        (!port_selected(cs_n, cs)) |=> (q_wr == '0 && q_rd == '0));

endmodule

// File: rtl/dpram_core.sv
module dpram_core
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
    input  logic [PORTS-1:0][DATA_W-1:0]  wdata,
    input  logic [PORTS-1:0][LANES-1:0]   wr,
    output logic [PORTS-1:0][DATA_W-1:0]  rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];

    // Right lanes first, left lanes second: on a shared word and lane the
    // later nonblocking update (left) is the one that lands.
    always_ff @(posedge clk) begin
        for (int g = 0; g < LANES; g++) begin
            if (wr[P_RIGHT][g]) begin
                mem[addr[P_RIGHT]][g*LANE_W +: LANE_W] <= wdata[P_RIGHT][g*LANE_W +: LANE_W];
            end
            if (wr[P_LEFT][g]) begin
                mem[addr[P_LEFT]][g*LANE_W +: LANE_W] <= wdata[P_LEFT][g*LANE_W +: LANE_W];
            end
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        assign rdata[p] = mem[addr[p]];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R10: a lane written by both ports at one word keeps the left data
        p_left_wins_r10: assert property (@(posedge clk) disable iff (rst)
            (wr[P_LEFT][g] && wr[P_RIGHT][g] && addr[P_LEFT] == addr[P_RIGHT])
            |=> (mem[$past(addr[P_LEFT])][g*LANE_W +: LANE_W]
                 == $past(wdata[P_LEFT][g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
    import dpram_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_mode_e          mode,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [LANES-1:0]  rd_lanes,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  drive
);

    localparam int LANE_W = DATA_W / LANES;

    typedef struct packed {
        logic [LANES-1:0]  drv;
        logic [DATA_W-1:0] data;
    } rd_beat_t;

    rd_beat_t flow_b;
    rd_beat_t pipe_q;
    rd_beat_t pick_b;

    always_comb begin
        flow_b.drv = rd_lanes;
        for (int g = 0; g < LANES; g++) begin
            flow_b.data[g*LANE_W +: LANE_W] =
                rd_lanes[g] ? mem_rdata[g*LANE_W +: LANE_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= flow_b;
        end
    end

    assign pick_b = (mode == RD_PIPE) ? pipe_q : flow_b;
    assign drive  = oe_n ? '0 : pick_b.drv;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*LANE_W +: LANE_W] =
            drive[g] ? pick_b.data[g*LANE_W +: LANE_W] : '0;
    end

    // R5: in pipelined mode the flags trail the captured read lanes by one edge
    p_pipe_one_late_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == RD_PIPE && !oe_n) |-> (drive == $past(rd_lanes)));

endmodule

// File: rtl/dpram_dual.sv
module dpram_dual
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cs_n,
    input  logic              l_cs,
    input  logic              l_rnw,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic              l_oe_n,
    input  logic              l_pipe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic [1:0]        l_drive,
    input  logic              r_cs_n,
    input  logic              r_cs,
    input  logic              r_rnw,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic              r_oe_n,
    input  logic              r_pipe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic [1:0]        r_drive
);

    logic [PORTS-1:0]             cs_n_a, cs_a, rnw_a, ub_n_a, lb_n_a, oe_n_a, pipe_a;
    logic [PORTS-1:0][ADDR_W-1:0] addr_a, q_addr;
    logic [PORTS-1:0][DATA_W-1:0] wdata_a, q_wdata, mem_rd, rdata_a;
    logic [PORTS-1:0][LANES-1:0]  q_wr, q_rd, drive_a;

    assign cs_n_a  = {r_cs_n,  l_cs_n};
    assign cs_a    = {r_cs,    l_cs};
    assign rnw_a   = {r_rnw,   l_rnw};
    assign ub_n_a  = {r_ub_n,  l_ub_n};
    assign lb_n_a  = {r_lb_n,  l_lb_n};
    assign oe_n_a  = {r_oe_n,  l_oe_n};
    assign pipe_a  = {r_pipe,  l_pipe};
    assign addr_a  = {r_addr,  l_addr};
    assign wdata_a = {r_wdata, l_wdata};

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        dpram_port_in #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
            .clk     (clk),
            .rst     (rst),
            .cs_n    (cs_n_a[p]),
            .cs      (cs_a[p]),
            .rnw     (rnw_a[p]),
            .ub_n    (ub_n_a[p]),
            .lb_n    (lb_n_a[p]),
            .addr    (addr_a[p]),
            .wdata   (wdata_a[p]),
            .q_addr  (q_addr[p]),
            .q_wdata (q_wdata[p]),
            .q_wr    (q_wr[p]),
            .q_rd    (q_rd[p])
        );

        dpram_port_out #(.DATA_W(DATA_W)) u_out (
            .clk       (clk),
            .rst       (rst),
            .mode      (rd_mode_e'(pipe_a[p])),
            .oe_n      (oe_n_a[p]),
            .mem_rdata (mem_rd[p]),
            .rd_lanes  (q_rd[p]),
            .rdata     (rdata_a[p]),
            .drive     (drive_a[p])
        );
    end

    dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .addr  (q_addr),
        .wdata (q_wdata),
        .wr    (q_wr),
        .rdata (mem_rd)
    );

    assign l_rdata = rdata_a[P_LEFT];
    assign r_rdata = rdata_a[P_RIGHT];
    assign l_drive = drive_a[P_LEFT];
    assign r_drive = drive_a[P_RIGHT];

    // R7: output enable high leaves no lane driven at any sampled edge
    p_oe_off_r7: assert property (@(posedge clk) disable iff (rst)
        (l_oe_n |-> l_drive == 2'b00) and (r_oe_n |-> r_drive == 2'b00));

    // R2: a disabled upper lane is not driven after the edge (flow-through)
    p_upper_lane_off_r2: assert property (@(posedge clk) disable iff (rst)
        (l_ub_n && !l_pipe) |=> !l_drive[1]);

    // R3: a write cycle never drives the read lanes (flow-through)
    p_write_no_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (!r_rnw && !r_pipe) |=> (r_drive == 2'b00));

endmodule

// File: tb/dpram_dual_tb_top.sv
`timescale 1ns/1ps
module dpram_dual_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        l_cs_n = 1'b1, l_cs = 1'b0, l_rnw = 1'b1, l_ub_n = 1'b1, l_lb_n = 1'b1;
    logic        l_oe_n = 1'b0, l_pipe = 1'b0;
    logic [7:0]  l_addr = '0;
    logic [15:0] l_wdata = '0;
    logic [15:0] l_rdata;
    logic [1:0]  l_drive;
    logic        r_cs_n = 1'b1, r_cs = 1'b0, r_rnw = 1'b1, r_ub_n = 1'b1, r_lb_n = 1'b1;
    logic        r_oe_n = 1'b0, r_pipe = 1'b0;
    logic [7:0]  r_addr = '0;
    logic [15:0] r_wdata = '0;
    logic [15:0] r_rdata;
    logic [1:0]  r_drive;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dpram_dual #(.ADDR_W(8), .DATA_W(16)) dut_i (
        .clk(clk), .rst(rst),
        .l_cs_n(l_cs_n), .l_cs(l_cs), .l_rnw(l_rnw), .l_ub_n(l_ub_n), .l_lb_n(l_lb_n),
        .l_oe_n(l_oe_n), .l_pipe(l_pipe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_drive(l_drive),
        .r_cs_n(r_cs_n), .r_cs(r_cs), .r_rnw(r_rnw), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n),
        .r_oe_n(r_oe_n), .r_pipe(r_pipe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_drive(r_drive)
    );

    // op = {cs_n, cs, rnw}; lanes = {ub_n, lb_n}
    localparam logic [2:0] RD = 3'b011, WR = 3'b010, IDLE = 3'b111;
    localparam logic [2:0] DSL = 3'b001, DSW = 3'b110;
    localparam logic [1:0] BOTH = 2'b00, UP = 2'b01, LO = 2'b10, NONE = 2'b11;

    typedef struct packed {
        logic [23:0] tag;
        logic [2:0]  lop;
        logic [1:0]  lln;
        logic [7:0]  la;
        logic [15:0] lw;
        logic [2:0]  rop;
        logic [1:0]  rln;
        logic [7:0]  ra;
        logic [15:0] rw;
        logic [1:0]  eld;
        logic [15:0] elr;
        logic [1:0]  erd;
        logic [15:0] err;
    } vec_t;

    function automatic vec_t mk(input logic [23:0] tag,
        input logic [2:0] lop, input logic [1:0] lln, input logic [7:0] la, input logic [15:0] lw,
        input logic [2:0] rop, input logic [1:0] rln, input logic [7:0] ra, input logic [15:0] rw,
        input logic [1:0] eld, input logic [15:0] elr, input logic [1:0] erd, input logic [15:0] err);
        vec_t v;
        v.tag = tag; v.lop = lop; v.lln = lln; v.la = la; v.lw = lw;
        v.rop = rop; v.rln = rln; v.ra = ra; v.rw = rw;
        v.eld = eld; v.elr = elr; v.erd = erd; v.err = err;
        return v;
    endfunction

    // Flow-through table: results are checked one falling edge after driving.
    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        mk("R3",  WR,  BOTH, 8'h10, 16'hA1B2, IDLE, NONE, 8'h00, 16'h0000, 2'b00, 16'h0000, 2'b00, 16'h0000),
        mk("R4",  RD,  BOTH, 8'h10, 16'h0000, WR,   UP,   8'h20, 16'h3344, 2'b11, 16'hA1B2, 2'b00, 16'h0000),
        mk("R4",  WR,  LO,   8'h20, 16'h5566, RD,   BOTH, 8'h10, 16'h0000, 2'b00, 16'h0000, 2'b11, 16'hA1B2),
        mk("R2",  RD,  BOTH, 8'h20, 16'h0000, RD,   UP,   8'h20, 16'h0000, 2'b11, 16'h3366, 2'b10, 16'h3300),
        mk("R10", WR,  UP,   8'h30, 16'h1122, WR,   BOTH, 8'h30, 16'h7788, 2'b00, 16'h0000, 2'b00, 16'h0000),
        mk("R10", RD,  BOTH, 8'h30, 16'h0000, RD,   LO,   8'h30, 16'h0000, 2'b11, 16'h1188, 2'b01, 16'h0088),
        mk("R10", WR,  BOTH, 8'h30, 16'h9999, WR,   BOTH, 8'h30, 16'h4444, 2'b00, 16'h0000, 2'b00, 16'h0000),
        mk("R11", RD,  BOTH, 8'h30, 16'h0000, WR,   BOTH, 8'h30, 16'h5555, 2'b11, 16'h9999, 2'b00, 16'h0000),
        mk("R11", RD,  BOTH, 8'h30, 16'h0000, DSL,  BOTH, 8'h30, 16'h0000, 2'b11, 16'h5555, 2'b00, 16'h0000),
        mk("R1",  IDLE,NONE, 8'h00, 16'h0000, DSW,  BOTH, 8'h30, 16'h0000, 2'b00, 16'h0000, 2'b00, 16'h0000),
        mk("R8",  RD,  BOTH, 8'h30, 16'h0000, RD,   NONE, 8'h30, 16'h0000, 2'b11, 16'h5555, 2'b00, 16'h0000),
        mk("R2",  IDLE,NONE, 8'h00, 16'h0000, WR,   NONE, 8'h30, 16'h0000, 2'b00, 16'h0000, 2'b00, 16'h0000),
        mk("R1",  RD,  BOTH, 8'h10, 16'h0000, RD,   BOTH, 8'h30, 16'h0000, 2'b11, 16'hA1B2, 2'b11, 16'h5555)
    };

    task automatic set_l(input logic [2:0] op, input logic [1:0] ln, input logic [7:0] a, input logic [15:0] w);
        {l_cs_n, l_cs, l_rnw} = op; {l_ub_n, l_lb_n} = ln; l_addr = a; l_wdata = w;
    endtask

    task automatic set_r(input logic [2:0] op, input logic [1:0] ln, input logic [7:0] a, input logic [15:0] w);
        {r_cs_n, r_cs, r_rnw} = op; {r_ub_n, r_lb_n} = ln; r_addr = a; r_wdata = w;
    endtask

    task automatic chk(input logic [23:0] tag, input string side,
                       input logic [1:0] gd, input logic [1:0] ed,
                       input logic [15:0] gr, input logic [15:0] er);
        n_cmp++;
        if (gd !== ed || gr !== er) begin
            n_bad++;
            $display("FAIL %s %s port: drive=%b data=%h, expected drive=%b data=%h",
                     tag, side, gd, gr, ed, er);
        end
    endtask

    initial begin
        // R12: reset holds every drive flag low even with a read requested
        set_l(RD, BOTH, 8'h10, 16'h0);
        set_r(RD, BOTH, 8'h10, 16'h0);
        repeat (3) @(negedge clk);
        chk("R12", "left",  l_drive, 2'b00, l_rdata, 16'h0000);
        chk("R12", "right", r_drive, 2'b00, r_rdata, 16'h0000);
        set_l(IDLE, NONE, 8'h0, 16'h0);
        set_r(IDLE, NONE, 8'h0, 16'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            set_l(TBL[i].lop, TBL[i].lln, TBL[i].la, TBL[i].lw);
            set_r(TBL[i].rop, TBL[i].rln, TBL[i].ra, TBL[i].rw);
            @(negedge clk);
            chk(TBL[i].tag, "left",  l_drive, TBL[i].eld, l_rdata, TBL[i].elr);
            chk(TBL[i].tag, "right", r_drive, TBL[i].erd, r_rdata, TBL[i].err);
        end

        // R7: output enable acts with no clock edge
        set_l(RD, BOTH, 8'h10, 16'h0);
        set_r(IDLE, NONE, 8'h0, 16'h0);
        @(negedge clk);
        chk("R4", "left", l_drive, 2'b11, l_rdata, 16'hA1B2);
        #1 l_oe_n = 1'b1;
        #0.5 chk("R7", "left", l_drive, 2'b00, l_rdata, 16'h0000);
        l_oe_n = 1'b0;
        #0.5 chk("R7", "left", l_drive, 2'b11, l_rdata, 16'hA1B2);

        // R9: repeated reads of one address hold the output
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9", "left", l_drive, 2'b11, l_rdata, 16'hA1B2);
        end

        // R5/R6: pipelined reads arrive one edge later and switch off one edge later
        set_l(IDLE, NONE, 8'h0, 16'h0);
        @(negedge clk);
        @(negedge clk);
        l_pipe = 1'b1;
        r_pipe = 1'b1;
        set_l(RD, BOTH, 8'h30, 16'h0);
        set_r(RD, UP, 8'h10, 16'h0);
        @(negedge clk);
        chk("R5", "left",  l_drive, 2'b00, l_rdata, 16'h0000);
        chk("R6", "right", r_drive, 2'b00, r_rdata, 16'h0000);
        @(negedge clk);
        chk("R5", "left",  l_drive, 2'b11, l_rdata, 16'h5555);
        chk("R5", "right", r_drive, 2'b10, r_rdata, 16'hA100);
        set_l(IDLE, NONE, 8'h0, 16'h0);
        @(negedge clk);
        chk("R6", "left",  l_drive, 2'b11, l_rdata, 16'h5555);
        chk("R9", "right", r_drive, 2'b10, r_rdata, 16'hA100);
        @(negedge clk);
        chk("R6", "left",  l_drive, 2'b00, l_rdata, 16'h0000);
        chk("R9", "right", r_drive, 2'b10, r_rdata, 16'hA100);

        // R6: flow-through lane disable takes effect after a single edge
        r_pipe = 1'b0;
        #0.5 chk("R4", "right", r_drive, 2'b10, r_rdata, 16'hA100);
        set_r(RD, LO, 8'h10, 16'h0);
        @(negedge clk);
        chk("R6", "right", r_drive, 2'b01, r_rdata, 16'h00B2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule